// File: doc/BRIEF.md
# DRAM Strobe Timing Monitor

This block watches the row strobe, the two byte-lane column strobes and the write strobe of an asynchronous DRAM bus. It samples them on a fast local clock and measures every pulse and every inter-strobe delay in sample ticks. When a minimum or maximum rule for the chosen speed grade is broken, the block sets a sticky error bit for that rule. It also freezes a free-running cycle stamp so that the first offending moment can be found later. The monitor only observes the bus, so it can sit beside a memory sequencer in simulation or on silicon. Every threshold is a tick-count parameter that is fixed at elaboration. The defaults suit a 500 MHz sampling clock.

The column strobe is active when either byte-lane strobe is low. A small state machine follows each row cycle. `ST_PRE` means the row strobe is high. From `ST_PRE`, a row fall goes to `ST_ROW`; a row fall while the column strobe is already low goes to `ST_CBR` (column-before-row refresh); a row fall in the same sample as a column fall goes straight to `ST_COL`. In `ST_ROW`, a column fall goes to `ST_COL` (first column cycle). In `ST_COL`, a further column fall goes to `ST_PAGE` (page mode). A row rise returns `ST_ROW`, `ST_COL`, `ST_PAGE` and `ST_CBR` to `ST_PRE`. The state decides which rules apply.

A pulse width is the number of samples the strobe held its level. A delay from edge A to edge B is the sample index of B minus that of A, and it is 0 when both edges land in the same sample. A minimum rule is broken when the count is below its threshold. A flag rises one clock after the sample that shows the offending edge.

Top module: `dram_timing_checker`

## Requirements
- R1: After reset, all twelve error bits and all stamps read zero.
- R2: The column strobe counts as asserted while ucas_n or lcas_n (or both) is low, so each byte lane alone can trigger every column rule.
- R3: A row-low pulse shorter than T_RAS_MIN sets bit 0. A row-high gap shorter than T_RP before a row fall sets bit 3.
- R4: Bit 1 is set when the row strobe rises after more than T_RAS_MAX low samples in a cycle that did not enter page mode. Bit 2 is set as soon as the row strobe has stayed low more than T_RASP_MAX samples, in any mode. Neither bit is judged before the row strobe's first edge after reset.
- R5: A column-low pulse shorter than T_CAS_MIN sets bit 4. A column-low run longer than T_CAS_MAX sets bit 5.
- R6: Inside a row cycle, a column-high gap shorter than T_CP before the next column fall sets bit 6.
- R7: A row-fall-to-first-column-fall delay below T_RCD sets bit 7. A refresh cycle whose column strobe fell before the row strobe is exempt.
- R8: A first column cycle that ends less than T_CSH samples after the row fall sets bit 8.
- R9: A row fall with the column strobe high, less than T_CRP samples after the column strobe rose, sets bit 9.
- R10: A write-low pulse shorter than T_WP sets bit 10. If the write strobe was low during an access row cycle and fell less than T_RWL samples before the row rise, bit 11 is set.
- R11: An error bit stays set until clr is high, and clr does not hide a violation that lands in the same cycle. Each bit's stamp keeps the cycle count of its first violation since the last clear.
- R12: Well-formed read, write, page and refresh cycles set no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clears all error bits |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| err_flags | output | 12 | Sticky error bits, index as in the requirements |
| err_stamp | output | 12*TS_W | Per-bit stamp, bit i in slice [i*TS_W +: TS_W] |

## Verification
A wrong cycle state would apply the wrong rule set. For example, a refresh cycle wrongly entered as a row access would raise bit 7 or bit 8. A second column cycle that never reaches page mode would raise bit 1 at the row rise. A miscounted width or delay shows up as a flag that is missing or extra, one boundary tick off. Each of these is visible at err_flags two clocks after the input change. A lost stamp or a flag cleared too early appears at the next read of err_stamp or err_flags.

// File: rtl/dram_tc_pkg.sv
package dram_tc_pkg;
    localparam int NCHK        = 12;
    localparam int CK_RAS_MIN  = 0;
    localparam int CK_RAS_MAX  = 1;
    localparam int CK_RASP_MAX = 2;
    localparam int CK_RP       = 3;
    localparam int CK_CAS_MIN  = 4;
    localparam int CK_CAS_MAX  = 5;
    localparam int CK_CP       = 6;
    localparam int CK_RCD      = 7;
    localparam int CK_CSH      = 8;
    localparam int CK_CRP      = 9;
    localparam int CK_WP       = 10;
    localparam int CK_RWL      = 11;

    typedef enum logic [2:0] {
        ST_PRE  = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_PAGE = 3'd3,
        ST_CBR  = 3'd4
    } cyc_state_t;
endpackage

// File: rtl/strobe_age.sv
module strobe_age #(
    parameter int W   = 16,
    parameter int LIM = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         raw_n,
    output logic         act,
    output logic         on,
    output logic         off,
    output logic         armed,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] SAT = W'(LIM);

    logic s_n, p_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_n <= 1'b1;
            p_n <= 1'b1;
        end else begin
            s_n <= raw_n;
            p_n <= s_n;
        end
    end

    assign act = ~s_n;
    assign on  = p_n & ~s_n;
    assign off = ~p_n & s_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age   <= SAT;
            armed <= 1'b0;
        end else if (on || off) begin
            age   <= W'(1);
            armed <= 1'b1;
        end else if (age != SAT) begin
            age   <= age + W'(1);
        end
    end
endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import dram_tc_pkg::*;
#(
    parameter int W   = 16,
    parameter int LIM = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ras_on,
    input  logic         ras_off,
    input  logic         cas_on,
    input  logic         cas_act,
    input  logic         we_on,
    input  logic         we_act,
    output cyc_state_t   state,
    output logic         wr_seen,
    output logic [W-1:0] we_since
);
    localparam logic [W-1:0] SAT = W'(LIM);

    cyc_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PRE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PRE: begin
                if (ras_on) begin
                    if (cas_on)       nxt = ST_COL;
                    else if (cas_act) nxt = ST_CBR;
                    else              nxt = ST_ROW;
                end
            end
            ST_ROW: begin
                if (ras_off)     nxt = ST_PRE;
                else if (cas_on) nxt = ST_COL;
            end
            ST_COL: begin
                if (ras_off)     nxt = ST_PRE;
                else if (cas_on) nxt = ST_PAGE;
            end
            ST_PAGE, ST_CBR: begin
                if (ras_off) nxt = ST_PRE;
            end
            default: nxt = ST_PRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen  <= 1'b0;
            we_since <= SAT;
        end else begin
            if (ras_off)
                wr_seen <= 1'b0;
            else if (we_act && (state == ST_ROW || state == ST_COL || state == ST_PAGE))
                wr_seen <= 1'b1;
            if (we_on)
                we_since <= W'(1);
            else if (we_since != SAT)
                we_since <= we_since + W'(1);
        end
    end
endmodule

// File: rtl/rule_eval.sv
module rule_eval
    import dram_tc_pkg::*;
#(
    parameter int W          = 16,
    parameter int T_RAS_MIN  = 23,
    parameter int T_RAS_MAX  = 5000,
    parameter int T_RASP_MAX = 50000,
    parameter int T_RP       = 15,
    parameter int T_CAS_MIN  = 4,
    parameter int T_CAS_MAX  = 5000,
    parameter int T_CP       = 4,
    parameter int T_RCD      = 8,
    parameter int T_CSH      = 20,
    parameter int T_CRP      = 3,
    parameter int T_WP       = 5,
    parameter int T_RWL      = 5
) (
    input  cyc_state_t      state,
    input  logic            wr_seen,
    input  logic            ras_act,
    input  logic            ras_on,
    input  logic            ras_off,
    input  logic            ras_armed,
    input  logic [W-1:0]    ras_age,
    input  logic            cas_act,
    input  logic            cas_on,
    input  logic            cas_off,
    input  logic            cas_armed,
    input  logic [W-1:0]    cas_age,
    input  logic            we_act,
    input  logic            we_on,
    input  logic            we_off,
    input  logic            we_armed,
    input  logic [W-1:0]    we_age,
    input  logic [W-1:0]    we_since,
    output logic [NCHK-1:0] hits
);
    localparam logic [W-1:0] L_RAS_MIN  = W'(T_RAS_MIN);
    localparam logic [W-1:0] L_RAS_MAX  = W'(T_RAS_MAX);
    localparam logic [W-1:0] L_RASP_MAX = W'(T_RASP_MAX);
    localparam logic [W-1:0] L_RP       = W'(T_RP);
    localparam logic [W-1:0] L_CAS_MIN  = W'(T_CAS_MIN);
    localparam logic [W-1:0] L_CAS_MAX  = W'(T_CAS_MAX);
    localparam logic [W-1:0] L_CP       = W'(T_CP);
    localparam logic [W-1:0] L_RCD      = W'(T_RCD);
    localparam logic [W-1:0] L_CSH      = W'(T_CSH);
    localparam logic [W-1:0] L_CRP      = W'(T_CRP);
    localparam logic [W-1:0] L_WP       = W'(T_WP);
    localparam logic [W-1:0] L_RWL      = W'(T_RWL);

    logic [W-1:0] rcd_delay;
    logic         in_access;

    assign rcd_delay = (state == ST_PRE) ? '0 : ras_age;
    assign in_access = (state == ST_ROW) || (state == ST_COL) || (state == ST_PAGE);

    always_comb begin
        hits = '0;
        hits[CK_RAS_MIN]  = ras_off && (ras_age < L_RAS_MIN);
        hits[CK_RAS_MAX]  = ras_off && ras_armed && (state != ST_PAGE) && (ras_age > L_RAS_MAX);
        hits[CK_RASP_MAX] = ras_act && !ras_on && ras_armed && (ras_age >= L_RASP_MAX);
        hits[CK_RP]       = ras_on && (ras_age < L_RP);
        hits[CK_CAS_MIN]  = cas_off && (cas_age < L_CAS_MIN);
        hits[CK_CAS_MAX]  = cas_act && !cas_on && cas_armed && (cas_age >= L_CAS_MAX);
        hits[CK_CP]       = cas_on && ((state == ST_COL) || (state == ST_PAGE)) && (cas_age < L_CP);
        hits[CK_RCD]      = cas_on && ((state == ST_ROW) || ((state == ST_PRE) && ras_on))
                            && (rcd_delay < L_RCD);
        hits[CK_CSH]      = cas_off && (state == ST_COL) && (ras_age < L_CSH);
        hits[CK_CRP]      = ras_on && !cas_act && (cas_off || (cas_age < L_CRP));
        hits[CK_WP]       = we_off && we_armed && (we_age < L_WP);
        hits[CK_RWL]      = ras_off && (wr_seen || (we_act && in_access))
                            && (we_on || (we_since < L_RWL));
    end
endmodule

// File: rtl/err_bank.sv
module err_bank #(
    parameter int NCHK = 12,
    parameter int TS_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NCHK-1:0]   hits,
    output logic [NCHK-1:0]   flags,
    output logic [NCHK*TS_W-1:0] stamps
);
    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + TS_W'(1);
    end

    for (genvar i = 0; i < NCHK; i++) begin : g_chk
        logic            flag_q;
        logic [TS_W-1:0] stamp_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q  <= 1'b0;
                stamp_q <= '0;
            end else begin
                flag_q <= (flag_q && !clr) || hits[i];
                if (hits[i] && (clr || !flag_q))
                    stamp_q <= ts_q;
            end
        end

        assign flags[i]                 = flag_q;
        assign stamps[i*TS_W +: TS_W]   = stamp_q;
    end
endmodule

// File: rtl/dram_timing_checker.sv
module dram_timing_checker
    import dram_tc_pkg::*;
#(
    parameter int T_RAS_MIN  = 23,
    parameter int T_RAS_MAX  = 5000,
    parameter int T_RASP_MAX = 50000,
    parameter int T_RP       = 15,
    parameter int T_CAS_MIN  = 4,
    parameter int T_CAS_MAX  = 5000,
    parameter int T_CP       = 4,
    parameter int T_RCD      = 8,
    parameter int T_CSH      = 20,
    parameter int T_CRP      = 3,
    parameter int T_WP       = 5,
    parameter int T_RWL      = 5,
    parameter int TS_W       = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ras_n,
    input  logic                 ucas_n,
    input  logic                 lcas_n,
    input  logic                 we_n,
    output logic [NCHK-1:0]      err_flags,
    output logic [NCHK*TS_W-1:0] err_stamp
);
    localparam int LIM = ((T_RASP_MAX > T_CAS_MAX) ? T_RASP_MAX : T_CAS_MAX) + 1;
    localparam int W   = $clog2(LIM + 1);

    logic         cas_raw_n;
    logic         ras_act, ras_on, ras_off, ras_armed;
    logic         cas_act, cas_on, cas_off, cas_armed;
    logic         we_act, we_on, we_off, we_armed;
    logic [W-1:0] ras_age, cas_age, we_age, we_since;
    logic         wr_seen;
    cyc_state_t   state;
    logic [NCHK-1:0] hits;

    assign cas_raw_n = ucas_n & lcas_n;

    strobe_age #(.W(W), .LIM(LIM)) u_ras (
        .clk(clk), .rst_n(rst_n), .raw_n(ras_n),
        .act(ras_act), .on(ras_on), .off(ras_off), .armed(ras_armed), .age(ras_age)
    );
    strobe_age #(.W(W), .LIM(LIM)) u_cas (
        .clk(clk), .rst_n(rst_n), .raw_n(cas_raw_n),
        .act(cas_act), .on(cas_on), .off(cas_off), .armed(cas_armed), .age(cas_age)
    );
    strobe_age #(.W(W), .LIM(LIM)) u_we (
        .clk(clk), .rst_n(rst_n), .raw_n(we_n),
        .act(we_act), .on(we_on), .off(we_off), .armed(we_armed), .age(we_age)
    );

    cycle_fsm #(.W(W), .LIM(LIM)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ras_on(ras_on), .ras_off(ras_off),
        .cas_on(cas_on), .cas_act(cas_act),
        .we_on(we_on), .we_act(we_act),
        .state(state), .wr_seen(wr_seen), .we_since(we_since)
    );

    rule_eval #(
        .W(W), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RASP_MAX(T_RASP_MAX),
        .T_RP(T_RP), .T_CAS_MIN(T_CAS_MIN), .T_CAS_MAX(T_CAS_MAX), .T_CP(T_CP),
        .T_RCD(T_RCD), .T_CSH(T_CSH), .T_CRP(T_CRP), .T_WP(T_WP), .T_RWL(T_RWL)
    ) u_rules (
        .state(state), .wr_seen(wr_seen),
        .ras_act(ras_act), .ras_on(ras_on), .ras_off(ras_off), .ras_armed(ras_armed), .ras_age(ras_age),
        .cas_act(cas_act), .cas_on(cas_on), .cas_off(cas_off), .cas_armed(cas_armed), .cas_age(cas_age),
        .we_act(we_act), .we_on(we_on), .we_off(we_off), .we_armed(we_armed), .we_age(we_age),
        .we_since(we_since), .hits(hits)
    );

    err_bank #(.NCHK(NCHK), .TS_W(TS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .hits(hits),
        .flags(err_flags), .stamps(err_stamp)
    );
endmodule

// File: rtl/dram_tc_chk.sv
module dram_tc_chk
    import dram_tc_pkg::*;
#(
    parameter int TS_W = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic [NCHK-1:0]      hits,
    input logic [NCHK-1:0]      err_flags,
    input logic [NCHK*TS_W-1:0] err_stamp,
    input cyc_state_t           state,
    input logic                 ras_armed
);
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> ((err_flags & $past(hits)) == $past(hits))); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R11
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hits == '0) |=> (err_flags == '0)); // R11
    AST_CBR_NO_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CBR) |-> !hits[CK_RCD]); // R7
    AST_MAX_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_armed |-> (!hits[CK_RAS_MAX] && !hits[CK_RASP_MAX])); // R4
    AST_PAGE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAGE && $past(state) != ST_PAGE) |-> ($past(state) == ST_COL)); // R6

    for (genvar i = 0; i < NCHK; i++) begin : g_stamp
        AST_STAMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && err_flags[i]) |=> $stable(err_stamp[i*TS_W +: TS_W])); // R11
    end
endmodule

bind dram_timing_checker dram_tc_chk #(.TS_W(TS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hits(hits),
    .err_flags(err_flags), .err_stamp(err_stamp),
    .state(state), .ras_armed(ras_armed)
);

// File: tb/dram_timing_checker_test.sv
module dram_timing_checker_test;
    localparam int TS_W = 16;
    localparam int NB   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1;
    logic [NB-1:0]      err_flags;
    logic [NB*TS_W-1:0] err_stamp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dram_timing_checker #(
        .T_RAS_MIN(9), .T_RAS_MAX(60), .T_RASP_MAX(200), .T_RP(6),
        .T_CAS_MIN(4), .T_CAS_MAX(50), .T_CP(4), .T_RCD(3), .T_CSH(8),
        .T_CRP(2), .T_WP(5), .T_RWL(5), .TS_W(TS_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ras_n(ras_n), .ucas_n(ucas_n),
        .lcas_n(lcas_n), .we_n(we_n), .err_flags(err_flags), .err_stamp(err_stamp)
    );

    task automatic step(input logic r, input logic u, input logic l, input logic w, input int n);
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_case();
        step(1, 1, 1, 1, 10);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_flags(input logic [NB-1:0] exp, input string tag);
        checks++;
        if (err_flags !== exp) begin
            fails++;
            $display("FAIL %s: flags=%b expected=%b", tag, err_flags, exp);
        end
    endtask

    function automatic logic [NB-1:0] bitm(input int i);
        return NB'(1) << i;
    endfunction

    task automatic t_reset();
        expect_flags('0, "R1 flags after reset");
        checks++;
        if (err_stamp !== '0) begin
            fails++;
            $display("FAIL R1 stamps: got=%h expected=0", err_stamp);
        end
    endtask

    task automatic t_legal();
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 6); step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags('0, "R12 legal read");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 0, 6); step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags('0, "R12 legal write");
        start_case();
        step(1, 0, 0, 1, 5); step(0, 0, 0, 1, 12); step(1, 0, 0, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags('0, "R7 R12 refresh with column first");
    endtask

    task automatic t_ras_widths();
        start_case();
        step(0, 1, 1, 1, 5); step(1, 1, 1, 1, 8);
        expect_flags(bitm(0), "R3 short row low");
        start_case();
        step(0, 1, 1, 1, 12); step(1, 1, 1, 1, 3); step(0, 1, 1, 1, 12); step(1, 1, 1, 1, 8);
        expect_flags(bitm(3), "R3 short row precharge");
    endtask

    task automatic t_ras_max();
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 10); step(0, 1, 1, 1, 5);
        step(0, 0, 0, 1, 10); step(0, 1, 1, 1, 51); step(1, 1, 1, 1, 8);
        expect_flags('0, "R4 long page cycle within page limit");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 10); step(0, 1, 1, 1, 56); step(1, 1, 1, 1, 8);
        expect_flags(bitm(1), "R4 single access too long");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 10); step(0, 1, 1, 1, 5);
        step(0, 0, 0, 1, 10); step(0, 1, 1, 1, 176); step(1, 1, 1, 1, 8);
        expect_flags(bitm(2), "R4 page cycle too long");
    endtask

    task automatic t_cas_widths();
        start_case();
        step(0, 1, 1, 1, 8); step(0, 1, 0, 1, 2); step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags(bitm(4), "R5 R2 short lower-lane column pulse");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 55); step(0, 1, 1, 1, 1); step(1, 1, 1, 1, 8);
        expect_flags(bitm(5), "R5 column low too long");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 5); step(0, 1, 1, 1, 2);
        step(0, 0, 0, 1, 5); step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags(bitm(6), "R6 short column precharge in page");
    endtask

    task automatic t_delays();
        start_case();
        step(0, 1, 1, 1, 1); step(0, 0, 1, 1, 10); step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags(bitm(7), "R7 R2 upper-lane column too soon after row");
        start_case();
        step(0, 1, 1, 1, 3); step(0, 0, 0, 1, 4); step(0, 1, 1, 1, 5); step(1, 1, 1, 1, 8);
        expect_flags(bitm(8), "R8 column released too early");
        start_case();
        step(1, 0, 0, 1, 5); step(1, 1, 1, 1, 1); step(0, 1, 1, 1, 12); step(1, 1, 1, 1, 8);
        expect_flags(bitm(9), "R9 row fall too soon after column rise");
    endtask

    task automatic t_write();
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 0, 2); step(0, 0, 0, 1, 4);
        step(0, 1, 1, 1, 2); step(1, 1, 1, 1, 8);
        expect_flags(bitm(10), "R10 short write pulse");
        start_case();
        step(0, 1, 1, 1, 4); step(0, 0, 0, 1, 6); step(0, 1, 1, 0, 3);
        step(1, 1, 1, 0, 3); step(1, 1, 1, 1, 8);
        expect_flags(bitm(11), "R10 write too close to row rise");
    endtask

    task automatic t_sticky();
        logic [TS_W-1:0] s1;
        start_case();
        step(0, 1, 1, 1, 5); step(1, 1, 1, 1, 8);
        s1 = err_stamp[TS_W-1:0];
        checks++;
        if (s1 == '0) begin
            fails++;
            $display("FAIL R11 stamp captured: got=%0d expected=nonzero", s1);
        end
        step(1, 1, 1, 1, 10);
        step(0, 1, 1, 1, 5); step(1, 1, 1, 1, 8);
        expect_flags(bitm(0), "R11 flag held across second violation");
        checks++;
        if (err_stamp[TS_W-1:0] !== s1) begin
            fails++;
            $display("FAIL R11 stamp kept: got=%0d expected=%0d", err_stamp[TS_W-1:0], s1);
        end
        clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
        expect_flags('0, "R11 clear empties flags");
        step(0, 1, 1, 1, 5); step(1, 1, 1, 1, 8);
        checks++;
        if (err_stamp[TS_W-1:0] <= s1) begin
            fails++;
            $display("FAIL R11 stamp renewed: got=%0d expected>%0d", err_stamp[TS_W-1:0], s1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legal();
        t_ras_widths();
        t_ras_max();
        t_cas_widths();
        t_delays();
        t_write();
        t_sticky();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule